// File: doc/BRIEF.md
# Transparent TDM Serial Byte Port

This block moves raw bytes between a processor-side write/read strobe interface and a time-division multiplexed serial line, with no framing protocol applied. Bytes written by the processor wait in a transmit queue. A serializer shifts them out, one bit per enabled bit slot. In the other direction, serial bits are gathered into bytes and pushed into a receive queue that the processor drains.

The serial timing comes from two single-cycle strobes in the block's clock domain. `bitTick` marks one serial bit period, and `frameSync` marks the tick that starts a frame. The active slot bits come from one of two sources, chosen by `extMode`:
- In internal mode, a position counter selects a slot of the chosen width, starting at a programmable bit offset inside each frame.
- In external mode, two enable inputs gate the transmit and receive directions independently, on any tick.

A slot may carry 8, 7, 6 or 2 bits of each byte. For narrower slots:
- The transmitter sends only the low bits of each byte.
- The receiver fills only the high bits of each byte.

When the transmit queue is empty, the last byte taken from it is sent again.

Top module: `tdm_byte_port`

## Requirements
- R1: After reset, txEmpty=1, rxEmpty=1, txFull=0, rxOverflow=0 and serOut=1. The repeat byte holds 8'hFF.
- R2: Each active transmit tick puts exactly one bit on serOut, most significant of the active bits first. serOut is registered and takes the new bit at the clock edge that samples the tick.
- R3: In external mode (extMode=1), a tick is active for transmit only when txSlotEn=1 and for receive only when rxSlotEn=1. On a tick that is not active for transmit, serOut is driven to 1 and the byte in progress does not advance. The transmit queue is not touched while transmit is disabled.
- R4: In internal mode (extMode=0), the tick carrying frameSync is frame position 0, and each following tick adds one. Positions slotStart to slotStart+w-1 are active for both directions, and txSlotEn/rxSlotEn are ignored.
- R5: widthSel selects the slot width w as follows: 2'b00 gives 8 bits, 2'b01 gives 7, 2'b10 gives 6 and 2'b11 gives 2. The transmitter sends bits w-1 down to 0 of each byte.
- R6: The receiver samples serIn on each active receive tick. After the w-th bit it pushes a byte with the received bits in positions 7 down to 8-w (first bit highest) and zeros below.
- R7: At the first bit of each transmitted byte, the head of a non-empty transmit queue is popped and sent. If the queue is empty, the last popped byte is resent instead.
- R8: The transmit queue holds 19 bytes. txFull is 1 when it holds 19 bytes, and a txWr while full is ignored.
- R9: The receive queue holds 19 bytes. rxData shows the oldest byte and rxRd pops it. A push while the queue is full discards the byte and sets rxOverflow. rxOverflow stays set until an rxRd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| extMode | input | 1 | 1: slot gating from txSlotEn/rxSlotEn; 0: internal slot selector |
| widthSel | input | 2 | Slot width code (8/7/6/2 bits) |
| slotStart | input | 8 | First frame position of the internal slot |
| bitTick | input | 1 | One-cycle strobe per serial bit period |
| frameSync | input | 1 | Marks the tick at frame position 0 |
| txSlotEn | input | 1 | External transmit slot enable |
| rxSlotEn | input | 1 | External receive slot enable |
| serIn | input | 1 | Serial receive data |
| serOut | output | 1 | Serial transmit data, idle high |
| txWr | input | 1 | Transmit byte write strobe |
| txData | input | 8 | Transmit byte |
| txFull | output | 1 | Transmit queue full |
| txEmpty | output | 1 | Transmit queue empty |
| rxRd | input | 1 | Receive byte read strobe |
| rxData | output | 8 | Oldest received byte |
| rxEmpty | output | 1 | Receive queue empty |
| rxOverflow | output | 1 | Sticky receive overflow flag |

## Verification
Errors in the slot or bit counters show up at serOut right away: a bit lands at the wrong frame position, or an idle 1 appears where a data bit belongs. The same fault corrupts the next received byte, which can be seen as soon as it reaches rxData. Queue pointer or count faults show up within one queue depth of writes or pushes: txFull or rxOverflow rises at the wrong moment, bytes come out of order, or the repeated byte is wrong. Narrow-width mistakes show up on the first byte, as shifted bits or non-zero low bits in received bytes.

// File: rtl/tdm_port_pkg.sv
package tdm_port_pkg;

  typedef struct packed {
    logic tick;     // a bit period occurs this cycle
    logic txBit;    // transmit active on this tick
    logic txFirst;  // first bit of a transmit byte
    logic rxBit;    // receive active on this tick
    logic rxLast;   // last bit of a receive byte
  } slotStrobe_t;

  function automatic logic [3:0] slotBits(input logic [1:0] sel);
    case (sel)
      2'b00:   slotBits = 4'd8;
      2'b01:   slotBits = 4'd7;
      2'b10:   slotBits = 4'd6;
      default: slotBits = 4'd2;
    endcase
  endfunction

endpackage

// File: rtl/tdm_byte_fifo.sv
module tdm_byte_fifo #(
  parameter int DEPTH = 19,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wData,
  input  logic          rd,
  output logic [DW-1:0] rData,
  output logic          empty,
  output logic          full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic doWr, doRd;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign doWr  = wr && !full;
  assign doRd  = rd && !empty;
  assign rData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doWr) mem[wrPtr] <= wData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doWr) wrPtr <= (wrPtr == PW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doRd) rdPtr <= (rdPtr == PW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({doWr, doRd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R8/R9: occupancy never exceeds the depth
  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R8: a write while full without a read leaves the occupancy unchanged
  p_full_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr && !rd |=> full);

endmodule

// File: rtl/tdm_slot_ctrl.sv
module tdm_slot_ctrl
  import tdm_port_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int POS_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             extMode,
  input  logic [1:0]       widthSel,
  input  logic [POS_W-1:0] slotStart,
  input  logic             bitTick,
  input  logic             frameSync,
  input  logic             txSlotEn,
  input  logic             rxSlotEn,
  output slotStrobe_t      strobe
);
  logic [POS_W-1:0] bitPos, curPos;
  logic [3:0]       w;
  logic [2:0]       txCnt, rxCnt, txCntEff, rxCntEff;
  logic             inSlot, frameClr, txAct, rxAct;

  assign w        = slotBits(widthSel);
  assign curPos   = frameSync ? '0 : bitPos;
  assign inSlot   = ({1'b0, curPos} >= {1'b0, slotStart}) &&
                    ({1'b0, curPos} <  ({1'b0, slotStart} + (POS_W+1)'(w)));
  assign frameClr = bitTick && frameSync && !extMode;
  assign txAct    = bitTick && (extMode ? txSlotEn : inSlot);
  assign rxAct    = bitTick && (extMode ? rxSlotEn : inSlot);
  assign txCntEff = frameClr ? '0 : txCnt;
  assign rxCntEff = frameClr ? '0 : rxCnt;

  assign strobe.tick    = bitTick;
  assign strobe.txBit   = txAct;
  assign strobe.txFirst = txAct && (txCntEff == '0);
  assign strobe.rxBit   = rxAct;
  assign strobe.rxLast  = rxAct && ({1'b0, rxCntEff} == w - 4'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitPos <= '0;
      txCnt  <= '0;
      rxCnt  <= '0;
    end else if (bitTick) begin
      bitPos <= curPos + 1'b1;
      if (txAct) txCnt <= ({1'b0, txCntEff} == w - 4'd1) ? '0 : txCntEff + 1'b1;
      else       txCnt <= txCntEff;
      if (rxAct) rxCnt <= ({1'b0, rxCntEff} == w - 4'd1) ? '0 : rxCntEff + 1'b1;
      else       rxCnt <= rxCntEff;
    end
  end

  // R2: a byte start is only ever flagged on an active transmit tick
  p_first_on_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.txFirst |-> strobe.txBit && bitTick);

  // R4: in internal mode both directions share one slot
  p_shared_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !extMode |-> (strobe.txBit == strobe.rxBit));

endmodule

// File: rtl/tdm_byte_dp.sv
module tdm_byte_dp
  import tdm_port_pkg::*;
#(
  parameter int FIFO_DEPTH = 19
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  widthSel,
  input  slotStrobe_t strobe,
  input  logic        serIn,
  output logic        serOut,
  input  logic        txWr,
  input  logic [7:0]  txData,
  output logic        txFull,
  output logic        txEmpty,
  input  logic        rxRd,
  output logic [7:0]  rxData,
  output logic        rxEmpty,
  output logic        rxOverflow
);
  logic [3:0] w, padBits;
  logic [7:0] txHead, lastByte, txShift, loadByte, loadAligned;
  logic [7:0] rxAcc, rxNext, rxAligned;
  logic       txPop, rxFull;

  assign w           = slotBits(widthSel);
  assign padBits     = 4'd8 - w;
  assign loadByte    = txEmpty ? lastByte : txHead;
  assign loadAligned = loadByte << padBits;
  assign txPop       = strobe.txFirst && !txEmpty;
  assign rxNext      = {rxAcc[6:0], serIn};
  assign rxAligned   = rxNext << padBits;

  tdm_byte_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_txFifo (
    .clk(clk), .rst_n(rst_n),
    .wr(txWr), .wData(txData),
    .rd(txPop), .rData(txHead),
    .empty(txEmpty), .full(txFull)
  );

  tdm_byte_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_rxFifo (
    .clk(clk), .rst_n(rst_n),
    .wr(strobe.rxLast), .wData(rxAligned),
    .rd(rxRd), .rData(rxData),
    .empty(rxEmpty), .full(rxFull)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      serOut   <= 1'b1;
      txShift  <= '0;
      lastByte <= 8'hFF;
    end else if (strobe.txBit) begin
      if (strobe.txFirst) begin
        serOut  <= loadAligned[7];
        txShift <= loadAligned << 1;
        if (!txEmpty) lastByte <= txHead;
      end else begin
        serOut  <= txShift[7];
        txShift <= txShift << 1;
      end
    end else if (strobe.tick) begin
      serOut <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxAcc      <= '0;
      rxOverflow <= 1'b0;
    end else begin
      if (strobe.rxBit) rxAcc <= rxNext;
      if (strobe.rxLast && rxFull) rxOverflow <= 1'b1;
      else if (rxRd)               rxOverflow <= 1'b0;
    end
  end

  // R3: a tick without transmit activity leaves the line high
  p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.tick && !strobe.txBit |=> serOut);

  // R9: the overflow flag persists until a read
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rxOverflow && !rxRd |=> rxOverflow);

  // R7: an empty queue is never popped
  p_no_pop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    txEmpty && !txWr |=> txEmpty);

endmodule

// File: rtl/tdm_byte_port.sv
module tdm_byte_port
  import tdm_port_pkg::*;
#(
  parameter int FIFO_DEPTH = 19,
  parameter int FRAME_BITS = 256,
  localparam int POS_W     = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             extMode,
  input  logic [1:0]       widthSel,
  input  logic [POS_W-1:0] slotStart,
  input  logic             bitTick,
  input  logic             frameSync,
  input  logic             txSlotEn,
  input  logic             rxSlotEn,
  input  logic             serIn,
  output logic             serOut,
  input  logic             txWr,
  input  logic [7:0]       txData,
  output logic             txFull,
  output logic             txEmpty,
  input  logic             rxRd,
  output logic [7:0]       rxData,
  output logic             rxEmpty,
  output logic             rxOverflow
);
  slotStrobe_t strobe;

  tdm_slot_ctrl #(.FRAME_BITS(FRAME_BITS), .POS_W(POS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .extMode(extMode), .widthSel(widthSel),
    .slotStart(slotStart), .bitTick(bitTick), .frameSync(frameSync),
    .txSlotEn(txSlotEn), .rxSlotEn(rxSlotEn), .strobe(strobe)
  );

  tdm_byte_dp #(.FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .widthSel(widthSel), .strobe(strobe),
    .serIn(serIn), .serOut(serOut),
    .txWr(txWr), .txData(txData), .txFull(txFull), .txEmpty(txEmpty),
    .rxRd(rxRd), .rxData(rxData), .rxEmpty(rxEmpty), .rxOverflow(rxOverflow)
  );

endmodule

// File: tb/tdm_byte_port_bench.sv
module tdm_byte_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       extMode = 1'b1;
  logic [1:0] widthSel = 2'b00;
  logic [7:0] slotStart = 8'd0;
  logic       bitTick = 1'b0, frameSync = 1'b0, txSlotEn = 1'b0, rxSlotEn = 1'b0;
  logic       serIn = 1'b0, serOut;
  logic       txWr = 1'b0, txFull, txEmpty;
  logic [7:0] txData = 8'h00;
  logic       rxRd = 1'b0, rxEmpty, rxOverflow;
  logic [7:0] rxData;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  tdm_byte_port u_tdm_byte_port (
    .clk(clk), .rst_n(rst_n), .extMode(extMode), .widthSel(widthSel),
    .slotStart(slotStart), .bitTick(bitTick), .frameSync(frameSync),
    .txSlotEn(txSlotEn), .rxSlotEn(rxSlotEn), .serIn(serIn), .serOut(serOut),
    .txWr(txWr), .txData(txData), .txFull(txFull), .txEmpty(txEmpty),
    .rxRd(rxRd), .rxData(rxData), .rxEmpty(rxEmpty), .rxOverflow(rxOverflow)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic tick(input logic fs, input logic te, input logic re,
                      input logic sin, output logic so);
    @(negedge clk);
    bitTick = 1'b1; frameSync = fs; txSlotEn = te; rxSlotEn = re; serIn = sin;
    @(negedge clk);
    bitTick = 1'b0; frameSync = 1'b0;
    so = serOut;
  endtask

  task automatic writeTx(input logic [7:0] b);
    @(negedge clk); txWr = 1'b1; txData = b;
    @(negedge clk); txWr = 1'b0;
  endtask

  task automatic readRx(output logic [7:0] b);
    @(negedge clk); b = rxData; rxRd = 1'b1;
    @(negedge clk); rxRd = 1'b0;
  endtask

  // external mode: send n transmit bits, return them packed (first bit highest)
  task automatic txBitsExt(input int n, output logic [7:0] got);
    logic so;
    got = '0;
    for (int i = 0; i < n; i++) begin
      tick(1'b0, 1'b1, 1'b0, 1'b0, so);
      got = {got[6:0], so};
    end
  endtask

  task automatic rxByteExt(input logic [7:0] b);
    logic so;
    for (int i = 7; i >= 0; i--) tick(1'b0, 1'b0, 1'b1, b[i], so);
  endtask

  task automatic testReset();
    doReset();
    check("R1 txEmpty", {7'd0, txEmpty}, 8'd1);
    check("R1 rxEmpty", {7'd0, rxEmpty}, 8'd1);
    check("R1 txFull", {7'd0, txFull}, 8'd0);
    check("R1 rxOverflow", {7'd0, rxOverflow}, 8'd0);
    check("R1 serOut", {7'd0, serOut}, 8'd1);
  endtask

  task automatic testExtGating();
    logic so;
    logic [7:0] got;
    logic exp [9] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
    doReset();
    extMode = 1'b1; widthSel = 2'b00;
    tick(1'b0, 1'b1, 1'b0, 1'b0, so);
    check("R1 repeat byte FF after reset", {7'd0, so}, 8'd1);
    for (int i = 1; i < 8; i++) tick(1'b0, 1'b1, 1'b0, 1'b0, so);
    writeTx(8'hA5);
    for (int i = 0; i < 9; i++) begin
      tick(1'b0, (i != 3), 1'b0, 1'b1, so);
      check($sformatf("R2 R3 A5 bit step %0d", i), {7'd0, so}, {7'd0, exp[i]});
    end
    check("R3 rx disabled, nothing received", {7'd0, rxEmpty}, 8'd1);
    check("R7 queue drained", {7'd0, txEmpty}, 8'd1);
    txBitsExt(8, got);
    check("R7 repeat last byte", got, 8'hA5);
  endtask

  task automatic testInternal();
    logic so;
    logic [7:0] got;
    logic expo [8] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
    doReset();
    extMode = 1'b0; widthSel = 2'b11; slotStart = 8'd3;
    writeTx(8'hC6);
    for (int p = 0; p < 8; p++) begin
      tick(p == 0, 1'b1, 1'b1, (p == 3 || p == 4), so);
      check($sformatf("R4 R5 internal pos %0d", p), {7'd0, so}, {7'd0, expo[p]});
    end
    check("R4 tx slot consumed byte", {7'd0, txEmpty}, 8'd1);
    check("R6 one byte received", {7'd0, rxEmpty}, 8'd0);
    readRx(got);
    check("R6 2-bit receive high bits", got, 8'hC0);
    check("R4 only one slot per frame", {7'd0, rxEmpty}, 8'd1);
  endtask

  task automatic testNarrow();
    logic so;
    logic [7:0] got;
    logic bits [6] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
    doReset();
    extMode = 1'b1; widthSel = 2'b10;
    writeTx(8'h3C);
    for (int i = 0; i < 6; i++) begin
      tick(1'b0, 1'b0, 1'b1, bits[i], so);
      check("R3 tx disabled keeps line high", {7'd0, so}, 8'd1);
      if (i == 4) check("R6 no push before last bit", {7'd0, rxEmpty}, 8'd1);
    end
    check("R3 tx queue untouched", {7'd0, txEmpty}, 8'd0);
    readRx(got);
    check("R6 6-bit receive", got, 8'hB4);
    txBitsExt(6, got);
    check("R5 6-bit transmit low bits", got, 8'h3C);
    widthSel = 2'b01;
    doReset();
    writeTx(8'h55);
    txBitsExt(7, got);
    check("R5 7-bit transmit low bits", got, 8'h55);
  endtask

  task automatic testTxFull();
    logic [7:0] got;
    doReset();
    extMode = 1'b1; widthSel = 2'b00;
    for (int i = 0; i < 19; i++) writeTx(8'h40 + 8'(i));
    check("R8 full at 19", {7'd0, txFull}, 8'd1);
    writeTx(8'hEE);
    for (int i = 0; i < 19; i++) begin
      txBitsExt(8, got);
      check($sformatf("R8 drain byte %0d", i), got, 8'h40 + 8'(i));
      if (i == 0) check("R8 not full after pop", {7'd0, txFull}, 8'd0);
    end
    check("R8 empty after drain", {7'd0, txEmpty}, 8'd1);
    txBitsExt(8, got);
    check("R7 R8 repeat is last accepted byte", got, 8'h52);
  endtask

  task automatic testRxOverflow();
    logic [7:0] got;
    doReset();
    extMode = 1'b1; widthSel = 2'b00;
    for (int i = 0; i < 19; i++) rxByteExt(8'h80 + 8'(i));
    check("R9 no overflow at 19", {7'd0, rxOverflow}, 8'd0);
    rxByteExt(8'h11);
    check("R9 overflow on 20th", {7'd0, rxOverflow}, 8'd1);
    for (int i = 0; i < 19; i++) begin
      readRx(got);
      check($sformatf("R9 read byte %0d", i), got, 8'h80 + 8'(i));
      if (i == 0) check("R9 overflow cleared by read", {7'd0, rxOverflow}, 8'd0);
    end
    check("R9 extra byte discarded", {7'd0, rxEmpty}, 8'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    testReset();
    testExtGating();
    testInternal();
    testNarrow();
    testTxFull();
    testRxOverflow();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule